// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a register copy of every word of a one-time-programmable fuse array, so that software can read fuse contents over the register bus with no wait states instead of going through the slow fuse sense path. The shadow words sit on a fixed grid in the bus address space. Word `i` lives at byte offset `0x400 + 16*i`. Every other offset reads as zero.

A reload request starts a sequencer that walks the fuse array from word 0 upward. It holds each fuse address for a fixed number of strobe cycles and then copies the sensed word into its shadow register. While the walk runs, a busy flag stays high. A one-cycle done pulse marks the end of the walk. The control logic polls the busy flag.

Each word has its own read-lock and write-lock input. Any of the following sets a sticky error flag, which stays set until software clears it:

- reading a read-locked word, which also returns a poison value;
- writing a write-locked word;
- writing any shadow word while a reload is running.

While the error flag is set, the bank refuses all further accesses and all reload requests.

Top module: `fuse_shadow_bank`

## Requirements
- R1: Shadow word `i` (0 <= i < NUM_WORDS) is selected by byte address `0x400 + 16*i`. A read of any other address returns 0. A write to any other address changes no word and does not set the error flag.
- R2: A read of a mapped, unlocked word while the error flag is clear returns the shadow value on `bus_rdata` in the same cycle as the request, with no wait state. Data written by an accepted write is readable from the next cycle on.
- R3: A read of a word whose `rd_lock` bit is set returns `0xBADABADA` in the same cycle and sets `err_flag` at the next clock edge.
- R4: `err_flag` stays set until `err_clr` is sampled high. While it is set:
  - every mapped read returns `0xBADABADA`;
  - every write is discarded;
  - `reload_req` is ignored.
  An access sampled in the same cycle as `err_clr` is still refused.
- R5: A write to a word whose `wr_lock` bit is set is discarded and sets `err_flag` at the next clock edge.
- R6: A write to any mapped word while `reload_busy` is high sets `err_flag`. The write is discarded, so the word ends the reload holding the fuse value.
- R7: A reload request accepted at clock edge E raises `reload_busy` at E. The sequencer then:
  - presents fuse word `c / STROBE_CYC` on `fuse_rd_addr` during cycle `c` after E, with `fuse_rd_en` high;
  - loads shadow word `k` at edge `E + (k+1)*STROBE_CYC`;
  - drops `reload_busy` at edge `E + NUM_WORDS*STROBE_CYC`, pulsing `reload_done` high for exactly that one cycle.
- R8: During a reload, reads return the current shadow contents. Words already copied show the fuse value; the others still show their earlier contents.
- R9: A `reload_req` sampled while a reload is running is ignored and does not restart or lengthen the walk.
- R10: After reset, all shadow words read 0, and `reload_busy`, `reload_done`, `err_flag` and `fuse_rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| reload_req | input | 1 | Start a reload of every shadow word |
| reload_busy | output | 1 | High while a reload is running |
| reload_done | output | 1 | One-cycle pulse when a reload completes |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky access error |
| fuse_rd_en | output | 1 | Fuse array read strobe |
| fuse_rd_addr | output | IDX_W | Fuse word being sensed |
| fuse_rd_data | input | 32 | Sensed fuse word for `fuse_rd_addr` |
| rd_lock | input | NUM_WORDS | Per-word read lock |
| wr_lock | input | NUM_WORDS | Per-word write lock |

## Verification
The hardest situations to reach are collisions with a running reload:

- a read that lands exactly on the boundary between copied and not-yet-copied words;
- a write aimed at a word the sequencer has already passed, so that the rejected write would otherwise survive the reload;
- a second reload request arriving mid-walk.

The bench counts cycles from the rise of `reload_busy` and injects each of these accesses at computed offsets. It derives the expected value of every word from that offset and the strobe length. It also checks the fuse address on every cycle of the walk and the exact cycle at which busy falls.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    typedef logic [31:0] word_t;

    // Value returned for refused reads
    localparam word_t POISON_WORD = 32'hBADA_BADA;

    // Shadow window placement in the byte address space
    localparam int SHADOW_BASE        = 'h400;
    localparam int SHADOW_STRIDE_LOG2 = 4;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/fsb_addr_decode.sv
module fsb_addr_decode
    import fsb_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int ADDR_W    = 12,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(SHADOW_BASE);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_WORDS);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] slot;
    logic              above_base;
    logic              aligned;
    logic              in_range;

    always_comb begin
        rel        = addr - BASE;
        slot       = rel >> SHADOW_STRIDE_LOG2;
        above_base = (addr >= BASE);
        aligned    = (rel[SHADOW_STRIDE_LOG2-1:0] == '0);
        in_range   = (slot < LIMIT);
        hit        = above_base && aligned && in_range;
        idx        = slot[IDX_W-1:0];
    end

endmodule

// File: rtl/fsb_reload_seq.sv
module fsb_reload_seq #(
    parameter int NUM_WORDS  = 64,
    parameter int STROBE_CYC = 4,
    localparam int IDX_W     = $clog2(NUM_WORDS),
    localparam int CNT_W     = $clog2(STROBE_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_addr,
    output logic             load_en
);

    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(STROBE_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic strobe_end;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        strobe_end = seq_q.busy && (seq_q.cnt == LAST_CNT);
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy = 1'b1;
                seq_d.idx  = '0;
                seq_d.cnt  = '0;
            end
        end else if (strobe_end) begin
            seq_d.cnt = '0;
            if (seq_q.idx == LAST_WORD) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.idx  = '0;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end else begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = seq_q.busy;
    assign done    = seq_q.done;
    assign rd_en   = seq_q.busy;
    assign rd_addr = seq_q.idx;
    assign load_en = strobe_end;

    // R7: completion pulse accompanies the fall of busy
    p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.busy) |-> seq_q.done);

    // R7: done never overlaps an active walk
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> !seq_q.busy);

    // R7: the fuse address only ever advances by one during a walk
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && $past(seq_q.busy) && (seq_q.idx != $past(seq_q.idx)))
        |-> (seq_q.idx == $past(seq_q.idx) + 1'b1));

endmodule

// File: rtl/fsb_shadow_array.sv
module fsb_shadow_array
    import fsb_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  word_t            bus_wdata,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  word_t            load_data,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word
);

    word_t mem_d [NUM_WORDS];
    word_t mem_q [NUM_WORDS];

    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            mem_d[w] = mem_q[w];
            if (load_en && (load_idx == IDX_W'(w))) begin
                mem_d[w] = load_data;
            end else if (bus_we && (bus_idx == IDX_W'(w))) begin
                mem_d[w] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                mem_q[w] <= '0;
            end
        end else begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                mem_q[w] <= mem_d[w];
            end
        end
    end

    assign rd_word = mem_q[rd_idx];

    // R6: a bus write is never accepted while the sequencer is loading
    p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && load_en));

endmodule

// File: rtl/fsb_access_ctrl.sv
module fsb_access_ctrl
    import fsb_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 wr,
    input  logic                 hit,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_WORDS-1:0] rd_lock,
    input  logic [NUM_WORDS-1:0] wr_lock,
    input  logic                 reload_busy,
    input  logic                 reload_req,
    input  logic                 err_clr,
    output logic                 wr_accept,
    output logic                 rd_poison,
    output logic                 reload_start,
    output logic                 err
);

    typedef struct packed {
        logic err;
    } acc_t;

    acc_t      acc_d, acc_q;
    acc_kind_e kind;
    logic      fault;

    always_comb begin
        if (!sel || !hit) begin
            kind = ACC_NONE;
        end else if (wr) begin
            kind = ACC_WRITE;
        end else begin
            kind = ACC_READ;
        end

        wr_accept = 1'b0;
        rd_poison = 1'b0;
        fault     = 1'b0;
        case (kind)
            ACC_READ: begin
                rd_poison = acc_q.err || rd_lock[idx];
                fault     = !acc_q.err && rd_lock[idx];
            end
            ACC_WRITE: begin
                wr_accept = !acc_q.err && !reload_busy && !wr_lock[idx];
                fault     = !acc_q.err && (reload_busy || wr_lock[idx]);
            end
            default: ;
        endcase

        reload_start = reload_req && !reload_busy && !acc_q.err;

        acc_d     = acc_q;
        acc_d.err = (acc_q.err && !err_clr) || fault;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign err = acc_q.err;

    // R4: the flag holds until software clears it
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.err && !err_clr) |=> acc_q.err);

    // R4: the flag rises only after a mapped bus access
    p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_q.err) |-> $past(sel && hit));

endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
    import fsb_pkg::*;
#(
    parameter int NUM_WORDS  = 64,
    parameter int ADDR_W     = 12,
    parameter int STROBE_CYC = 4,
    localparam int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 reload_req,
    output logic                 reload_busy,
    output logic                 reload_done,
    input  logic                 err_clr,
    output logic                 err_flag,
    output logic                 fuse_rd_en,
    output logic [IDX_W-1:0]     fuse_rd_addr,
    input  logic [31:0]          fuse_rd_data,
    input  logic [NUM_WORDS-1:0] rd_lock,
    input  logic [NUM_WORDS-1:0] wr_lock
);

    logic             dec_hit;
    logic [IDX_W-1:0] dec_idx;
    logic             wr_accept;
    logic             rd_poison;
    logic             reload_start;
    logic             load_en;
    word_t            shadow_word;

    fsb_addr_decode #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr (bus_addr),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    fsb_access_ctrl #(
        .NUM_WORDS (NUM_WORDS)
    ) u_access (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (bus_sel),
        .wr           (bus_wr),
        .hit          (dec_hit),
        .idx          (dec_idx),
        .rd_lock      (rd_lock),
        .wr_lock      (wr_lock),
        .reload_busy  (reload_busy),
        .reload_req   (reload_req),
        .err_clr      (err_clr),
        .wr_accept    (wr_accept),
        .rd_poison    (rd_poison),
        .reload_start (reload_start),
        .err          (err_flag)
    );

    fsb_reload_seq #(
        .NUM_WORDS  (NUM_WORDS),
        .STROBE_CYC (STROBE_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (reload_start),
        .busy    (reload_busy),
        .done    (reload_done),
        .rd_en   (fuse_rd_en),
        .rd_addr (fuse_rd_addr),
        .load_en (load_en)
    );

    fsb_shadow_array #(
        .NUM_WORDS (NUM_WORDS)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (wr_accept),
        .bus_idx   (dec_idx),
        .bus_wdata (bus_wdata),
        .load_en   (load_en),
        .load_idx  (fuse_rd_addr),
        .load_data (fuse_rd_data),
        .rd_idx    (dec_idx),
        .rd_word   (shadow_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && dec_hit) begin
            bus_rdata = rd_poison ? POISON_WORD : shadow_word;
        end
    end

    // R1: unmapped reads return zero
    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !dec_hit) |-> (bus_rdata == '0));

    // R3: a read-locked word yields the poison value
    p_rlock_poison_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && dec_hit && rd_lock[dec_idx]) |-> (bus_rdata == POISON_WORD));

    // R5: a write to a write-locked word raises the error
    p_wlock_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && dec_hit && wr_lock[dec_idx]) |=> err_flag);

    // R6: a write during a reload raises the error
    p_busy_write_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && dec_hit && reload_busy) |=> err_flag);

endmodule

// File: tb/sim_fuse_shadow_bank.sv
`timescale 1ns/1ps
module sim_fuse_shadow_bank;

    localparam int NW = 64;
    localparam int S  = 3;
    localparam int AW = 12;
    localparam int IW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          reload_req = 1'b0;
    logic          reload_busy;
    logic          reload_done;
    logic          err_clr = 1'b0;
    logic          err_flag;
    logic          fuse_rd_en;
    logic [IW-1:0] fuse_rd_addr;
    logic [31:0]   fuse_rd_data;
    logic [NW-1:0] rd_lock = '0;
    logic [NW-1:0] wr_lock = '0;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [31:0] fuse_val(input int i);
        return 32'(i) * 32'h0103_0507 + 32'hC0DE_0000;
    endfunction

    function automatic logic [31:0] pat_val(input int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [AW-1:0] addr_of(input int i);
        return AW'(1024 + i * 16);
    endfunction

    assign fuse_rd_data = fuse_val(int'(fuse_rd_addr));

    fuse_shadow_bank #(
        .NUM_WORDS  (NW),
        .ADDR_W     (AW),
        .STROBE_CYC (S)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .reload_req   (reload_req),
        .reload_busy  (reload_busy),
        .reload_done  (reload_done),
        .err_clr      (err_clr),
        .err_flag     (err_flag),
        .fuse_rd_en   (fuse_rd_en),
        .fuse_rd_addr (fuse_rd_addr),
        .fuse_rd_data (fuse_rd_data),
        .rd_lock      (rd_lock),
        .wr_lock      (wr_lock)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic pulse_reload();
        @(negedge clk);
        reload_req = 1'b1;
        @(negedge clk);
        reload_req = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        int          addr_bad;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 err_flag", 32'(err_flag), 32'd0);
        chk("R10 reload_busy", 32'(reload_busy), 32'd0);
        chk("R10 reload_done", 32'(reload_done), 32'd0);
        chk("R10 fuse_rd_en", 32'(fuse_rd_en), 32'd0);
        for (int i = 0; i < NW; i++) begin
            do_read(addr_of(i), d);
            chk($sformatf("R10 word %0d after reset", i), d, 32'd0);
        end

        // R1/R2: write every word, read back
        for (int i = 0; i < NW; i++) begin
            do_write(addr_of(i), pat_val(i));
        end
        for (int i = 0; i < NW; i++) begin
            do_read(addr_of(i), d);
            chk($sformatf("R2 word %0d readback", i), d, pat_val(i));
        end
        chk("R2 no error after plain accesses", 32'(err_flag), 32'd0);

        // R1: unmapped offsets
        do_read(12'h404, d);  chk("R1 misaligned read", d, 32'd0);
        do_read(12'h000, d);  chk("R1 below window read", d, 32'd0);
        do_read(12'h3F0, d);  chk("R1 just below base read", d, 32'd0);
        do_read(addr_of(NW), d); chk("R1 past last word read", d, 32'd0);
        do_write(12'h408, 32'hFFFF_FFFF);
        do_write(addr_of(NW), 32'hFFFF_FFFF);
        do_read(addr_of(0), d); chk("R1 word 0 untouched by unmapped write", d, pat_val(0));
        do_read(addr_of(NW-1), d); chk("R1 last word untouched", d, pat_val(NW-1));
        chk("R1 unmapped write no error", 32'(err_flag), 32'd0);

        // R3: read-locked word
        rd_lock[5] = 1'b1;
        do_read(addr_of(5), d);
        chk("R3 read-locked returns poison", d, 32'hBADA_BADA);
        chk("R3 error set", 32'(err_flag), 32'd1);

        // R4: behaviour while error is set
        do_read(addr_of(6), d);
        chk("R4 unlocked read poisoned while error", d, 32'hBADA_BADA);
        do_write(addr_of(6), 32'h1234_5678);
        pulse_reload();
        chk("R4 reload ignored while error", 32'(reload_busy), 32'd0);
        chk("R4 no fuse strobe while error", 32'(fuse_rd_en), 32'd0);
        // access in the same cycle as clear is refused
        @(negedge clk);
        err_clr = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr_of(7); bus_wdata = 32'h0;
        @(negedge clk);
        err_clr = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        chk("R4 error cleared", 32'(err_flag), 32'd0);
        do_read(addr_of(6), d);
        chk("R4 write during error discarded", d, pat_val(6));
        do_read(addr_of(7), d);
        chk("R4 write in clear cycle discarded", d, pat_val(7));
        rd_lock[5] = 1'b0;
        do_read(addr_of(5), d);
        chk("R3 unlocked word 5 intact", d, pat_val(5));
        chk("R3 no error after unlock", 32'(err_flag), 32'd0);

        // R5: write-locked word
        wr_lock[9] = 1'b1;
        do_write(addr_of(9), 32'hDEAD_0009);
        chk("R5 error after locked write", 32'(err_flag), 32'd1);
        pulse_clr();
        wr_lock[9] = 1'b0;
        do_read(addr_of(9), d);
        chk("R5 locked word unchanged", d, pat_val(9));

        // R7/R8/R9/R6: reload walk
        pulse_reload();
        addr_bad = 0;
        for (int c = 0; c <= NW * S; c++) begin
            if (c > 0) @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0; reload_req = 1'b0;
            if (c < NW * S) begin
                if (reload_busy !== 1'b1 || fuse_rd_en !== 1'b1 ||
                    fuse_rd_addr !== IW'(c / S)) addr_bad++;
            end else begin
                chk("R7 busy low after N*S cycles", 32'(reload_busy), 32'd0);
                chk("R7 done pulse at end", 32'(reload_done), 32'd1);
            end
            if (c == 1) chk("R7 busy high after request", 32'(reload_busy), 32'd1);
            if (c == 20) reload_req = 1'b1;
            if (c == 31) begin
                bus_sel = 1'b1; bus_addr = addr_of(9);
                #1 chk("R8 copied word 9 mid-reload", bus_rdata, fuse_val(9));
                bus_addr = addr_of(10);
                #1 chk("R8 uncopied word 10 mid-reload", bus_rdata, pat_val(10));
            end
            if (c == 40) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr_of(2); bus_wdata = 32'hDEAD_BEEF;
            end
            if (c == 41) chk("R6 error after write during reload", 32'(err_flag), 32'd1);
            if (c == 60) chk("R7 done low mid-walk", 32'(reload_done), 32'd0);
        end
        chk("R7 fuse address sequence mismatches", 32'(addr_bad), 32'd0);
        chk("R9 second request did not extend walk", 32'(reload_busy), 32'd0);
        @(negedge clk);
        chk("R7 done is one cycle", 32'(reload_done), 32'd0);
        chk("R7 busy stays low", 32'(reload_busy), 32'd0);

        pulse_clr();
        for (int i = 0; i < NW; i++) begin
            do_read(addr_of(i), d);
            chk($sformatf("R7 word %0d holds fuse value", i), d, fuse_val(i));
        end
        do_read(addr_of(2), d);
        chk("R6 rejected write left no trace", d, fuse_val(2));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R7 actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule